// File: doc/BRIEF.md
# Undefined-Opcode Exception Entry Sequencer

This block sits next to the decode stage of a 16-bit processor. When decode reports that the opcode it fetched at an instruction boundary is not in the instruction map, the block takes over. It runs the entry sequence that a software interrupt with the fixed number 10 would run. It captures the processor context and the address of the offending opcode. It then writes the context to the system stack, one 16-bit word per clock, through a plain write port. The system stack pointer is pre-decremented by two before each word is written.

When the last word has been written, the block gives a one-cycle strobe. With the strobe come three values: the entry address of vector 10 in the vector table, the new status word, and the final stack pointer. In the new status word the interrupt-enable flag is cleared and the stack-select flag is set. The processor loads these values and branches. While the sequence runs, `busy` is high and the block ignores further requests.

Top module: `uexc_entry`

## Requirements
- R1: A request is accepted on a rising clock edge where `undef_req` is high and `busy` is low. `busy` is high from the cycle after acceptance through the cycle of the vector strobe, and low in the cycle after that.
- R2: After acceptance, the block writes exactly six words on six consecutive cycles. The first write appears in the cycle after acceptance. The addresses are `ssp_in`-2, -4, -6, -8, -10 and -12, taken modulo 2^16.
- R3: The words are written in this order: status word first, then program counter, then {program bank[15:8], data bank[7:0]}, then {additional-data bank[15:8], direct page[7:0]}, then accumulator high, then accumulator low.
- R4: The program counter word that is pushed equals `undef_pc`, the address of the undefined opcode.
- R5: The status word that is pushed is `psw_in` as it was when the request was accepted, before any flag is changed.
- R6: While the strobe is high, `psw_new` equals the saved status word with bit 6 (interrupt enable) cleared to 0 and bit 5 (stack select) set to 1. All other bits are unchanged.
- R7: `vec_valid` is high for exactly one cycle, the cycle after the last stack write. In that cycle `vec_addr` is 0xFFFC - 4*10 = 0xFFD4. Outside the strobe, `vec_addr` is 0.
- R8: While the strobe is high, `ssp_new` equals `ssp_in` - 12 modulo 2^16.
- R9: A request that arrives while `busy` is high is ignored. Context inputs that change during the sequence do not affect any written word or any strobe output.
- R10: While idle with no request, `stk_we`, `vec_valid` and `busy` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| undef_req | input | 1 | Undefined opcode reported at an instruction boundary |
| undef_pc | input | 16 | Address of the undefined opcode |
| acc_lo | input | 16 | Accumulator low half |
| acc_hi | input | 16 | Accumulator high half |
| dpage | input | 8 | Direct page register |
| dbank | input | 8 | Data bank register |
| xbank | input | 8 | Additional-data bank register |
| pbank | input | 8 | Program bank register |
| psw_in | input | 16 | Current status word |
| ssp_in | input | 16 | Current system stack pointer |
| busy | output | 1 | Sequence in progress |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 16 | Stack write data |
| vec_valid | output | 1 | One-cycle end-of-sequence strobe |
| vec_addr | output | 16 | Vector table entry address for number 10 |
| psw_new | output | 16 | Status word to load, I cleared and S set |
| ssp_new | output | 16 | Final system stack pointer |

## Verification
Internal faults show up at the ports within the seven cycles after acceptance:
- A wrong word index shows as a misordered or repeated word on `stk_wdata`, starting with the first write.
- A wrong stack pointer step shows as a wrong `stk_addr` in the same cycle.
- A wrong count of writes shows as `vec_valid` arriving early or late, or as a seventh write.
- A snapshot register that is not held shows as a changed word when the context inputs are disturbed in the middle of a sequence.
- A flag error appears only in `psw_new` during the strobe cycle.

// File: rtl/uexc_pkg.sv
package uexc_pkg;

    localparam int WORD_W  = 16;
    localparam int BANK_W  = 8;
    localparam int NWORDS  = 6;
    localparam int IDX_W   = $clog2(NWORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        word_t ps;
        word_t pc;
        bank_t pbank;
        bank_t dbank;
        bank_t xbank;
        bank_t dpage;
        word_t acc_hi;
        word_t acc_lo;
    } ctx_t;

    // Word pushed at step idx: status first, accumulator low last.
    function automatic word_t push_word(ctx_t c, logic [IDX_W-1:0] idx);
        word_t w;
        case (idx)
            IDX_W'(0): w = c.ps;
            IDX_W'(1): w = c.pc;
            IDX_W'(2): w = {c.pbank, c.dbank};
            IDX_W'(3): w = {c.xbank, c.dpage};
            IDX_W'(4): w = c.acc_hi;
            default:   w = c.acc_lo;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/uexc_snapshot.sv
module uexc_snapshot
    import uexc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  ctx_t ctx_in,
    output ctx_t ctx_q
);

    always_ff @(posedge clk) begin
        if (rst)       ctx_q <= '0;
        else if (load) ctx_q <= ctx_in;
    end

endmodule

// File: rtl/uexc_push_seq.sv
module uexc_push_seq
    import uexc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] sp_start,
    input  ctx_t              ctx,
    output logic              active,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output word_t             wdata,
    output logic              last,
    output logic [ADDR_W-1:0] sp_q
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NWORDS - 1);

    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] sp_dec;

    assign sp_dec = sp_q - STEP;
    assign we     = active;
    assign addr   = active ? sp_dec : '0;
    assign wdata  = active ? push_word(ctx, idx) : '0;
    assign last   = active && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            sp_q   <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            idx    <= '0;
            sp_q   <= sp_start;
        end else if (active) begin
            sp_q <= sp_dec;
            idx  <= idx + 1'b1;
            if (idx == LAST_IDX) active <= 1'b0;
        end
    end

    // R2: consecutive writes step down by one word
    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we)) |-> (addr == $past(addr) - STEP));

    // R2: a write burst never breaks before its last word
    p_burst_whole_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !last) |=> we);

endmodule

// File: rtl/uexc_vector.sv
module uexc_vector
    import uexc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 'hFFFC,
    parameter int EXC_NUM  = 10,
    parameter int I_BIT    = 6,
    parameter int S_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_last,
    input  word_t             ps_saved,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output word_t             psw_new
);

    localparam logic [ADDR_W-1:0] VEC_ENTRY = ADDR_W'(VEC_BASE - 4 * EXC_NUM);

    always_ff @(posedge clk) begin
        if (rst) vec_valid <= 1'b0;
        else     vec_valid <= push_last;
    end

    assign vec_addr = vec_valid ? VEC_ENTRY : '0;

    always_comb begin
        psw_new        = ps_saved;
        psw_new[I_BIT] = 1'b0;
        psw_new[S_BIT] = 1'b1;
    end

    // R7: the strobe lasts a single cycle
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R7: the strobe follows the final push
    p_strobe_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(push_last));

endmodule

// File: rtl/uexc_entry.sv
module uexc_entry
    import uexc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 'hFFFC,
    parameter int EXC_NUM  = 10,
    parameter int I_BIT    = 6,
    parameter int S_BIT    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              undef_req,
    input  logic [15:0]       undef_pc,
    input  logic [15:0]       acc_lo,
    input  logic [15:0]       acc_hi,
    input  logic [7:0]        dpage,
    input  logic [7:0]        dbank,
    input  logic [7:0]        xbank,
    input  logic [7:0]        pbank,
    input  logic [15:0]       psw_in,
    input  logic [ADDR_W-1:0] ssp_in,
    output logic              busy,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [15:0]       stk_wdata,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [15:0]       psw_new,
    output logic [ADDR_W-1:0] ssp_new
);

    ctx_t ctx_live, ctx_q;
    logic accept, push_active, push_last;
    logic [ADDR_W-1:0] sp_q;

    assign ctx_live = '{ps: psw_in, pc: undef_pc, pbank: pbank, dbank: dbank,
                        xbank: xbank, dpage: dpage, acc_hi: acc_hi, acc_lo: acc_lo};

    assign busy   = push_active || vec_valid;
    assign accept = undef_req && !busy;

    uexc_snapshot u_snap (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .ctx_in (ctx_live),
        .ctx_q  (ctx_q)
    );

    uexc_push_seq #(.ADDR_W(ADDR_W)) u_push (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .sp_start (ssp_in),
        .ctx      (ctx_q),
        .active   (push_active),
        .we       (stk_we),
        .addr     (stk_addr),
        .wdata    (stk_wdata),
        .last     (push_last),
        .sp_q     (sp_q)
    );

    uexc_vector #(
        .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .EXC_NUM(EXC_NUM),
        .I_BIT(I_BIT), .S_BIT(S_BIT)
    ) u_vec (
        .clk       (clk),
        .rst       (rst),
        .push_last (push_last),
        .ps_saved  (ctx_q.ps),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr),
        .psw_new   (psw_new)
    );

    assign ssp_new = sp_q;

    // R9: the captured context holds while a sequence runs
    p_ctx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctx_q));

    // R10: no stack write or strobe while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!stk_we && !vec_valid));

    // R1: busy stays up until the strobe
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && !vec_valid) |=> busy);

    // R6: flags forced at the strobe
    p_flags_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (!psw_new[I_BIT] && psw_new[S_BIT]));

endmodule

// File: tb/sim_uexc_entry.sv
module sim_uexc_entry;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        undef_req;
    logic [15:0] undef_pc, acc_lo, acc_hi, psw_in, ssp_in;
    logic [7:0]  dpage, dbank, xbank, pbank;
    logic        busy, stk_we, vec_valid;
    logic [15:0] stk_addr, stk_wdata, vec_addr, psw_new, ssp_new;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uexc_entry u0 (
        .clk(clk), .rst(rst), .undef_req(undef_req), .undef_pc(undef_pc),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .dpage(dpage), .dbank(dbank),
        .xbank(xbank), .pbank(pbank), .psw_in(psw_in), .ssp_in(ssp_in),
        .busy(busy), .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .vec_valid(vec_valid), .vec_addr(vec_addr), .psw_new(psw_new), .ssp_new(ssp_new)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ctx(input logic [15:0] pc, input logic [15:0] ps, input logic [15:0] sp,
                           input logic [15:0] lo, input logic [15:0] hi,
                           input logic [7:0] dp, input logic [7:0] db,
                           input logic [7:0] xb, input logic [7:0] pb);
        undef_pc = pc; psw_in = ps; ssp_in = sp; acc_lo = lo; acc_hi = hi;
        dpage = dp; dbank = db; xbank = xb; pbank = pb;
    endtask

    // Runs one sequence; if disturb is set, keeps req high and scrambles inputs.
    task automatic run_seq(input string name, input bit disturb);
        logic [15:0] e_words[6];
        logic [15:0] e_sp, e_ps;
        e_words[0] = psw_in;
        e_words[1] = undef_pc;
        e_words[2] = {pbank, dbank};
        e_words[3] = {xbank, dpage};
        e_words[4] = acc_hi;
        e_words[5] = acc_lo;
        e_sp = ssp_in;
        e_ps = psw_in;
        e_ps[6] = 1'b0;
        e_ps[5] = 1'b1;
        undef_req = 1'b1;
        check({name, " R1 busy low before accept"}, busy, 0);
        @(posedge clk);
        @(negedge clk);
        if (disturb) begin
            set_ctx(16'hDEAD, 16'h0000, 16'h4000, 16'h1111, 16'h2222,
                    8'h33, 8'h44, 8'h55, 8'h66);
        end else begin
            undef_req = 1'b0;
        end
        for (int k = 0; k < 6; k++) begin
            check({name, " R1 busy during push"}, busy, 1);
            check({name, " R2 write enable"}, stk_we, 1);
            check({name, " R2 address"}, stk_addr, 16'(e_sp - 16'(2 * (k + 1))));
            check({name, k == 1 ? " R4 pushed pc" : (k == 0 ? " R5 pushed ps" : " R3 word")},
                  stk_wdata, e_words[k]);
            if (disturb) check({name, " R9 word unaffected"}, stk_wdata, e_words[k]);
            check({name, " R7 no early strobe"}, vec_valid, 0);
            @(negedge clk);
        end
        check({name, " R2 no seventh write"}, stk_we, 0);
        check({name, " R7 strobe"}, vec_valid, 1);
        check({name, " R7 vector address"}, vec_addr, 16'hFFD4);
        check({name, " R6 new status"}, psw_new, e_ps);
        check({name, " R8 final stack pointer"}, ssp_new, 16'(e_sp - 16'd12));
        check({name, " R1 busy at strobe"}, busy, 1);
        undef_req = 1'b0;
        @(negedge clk);
        check({name, " R1 busy low after"}, busy, 0);
        check({name, " R7 strobe one cycle"}, vec_valid, 0);
        check({name, " R7 vec_addr zero"}, vec_addr, 0);
        check({name, " R9 no re-accept write"}, stk_we, 0);
        @(negedge clk);
        check({name, " R9 stays idle"}, busy, 0);
    endtask

    task automatic t_reset_idle();
        undef_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 idle busy", busy, 0);
            check("R10 idle write", stk_we, 0);
            check("R10 idle strobe", vec_valid, 0);
        end
    endtask

    task automatic t_basic();
        set_ctx(16'h1234, 16'h00E3, 16'h0800, 16'hA5A5, 16'h5A5A,
                8'h01, 8'h02, 8'h03, 8'hFF);
        run_seq("basic", 0);
    endtask

    task automatic t_flags_clear();
        set_ctx(16'hFFFE, 16'hFF9F, 16'h0100, 16'h0001, 16'h8000,
                8'h80, 8'h7F, 8'h00, 8'hC3);
        run_seq("flags", 0);
    endtask

    task automatic t_wrap();
        set_ctx(16'h0000, 16'h0040, 16'h0008, 16'hCAFE, 16'hBEEF,
                8'h10, 8'h20, 8'h30, 8'h40);
        run_seq("wrap", 0);
    endtask

    task automatic t_ignore_busy();
        set_ctx(16'h4321, 16'h0021, 16'h2000, 16'h0F0F, 16'hF0F0,
                8'hAA, 8'hBB, 8'hCC, 8'hDD);
        run_seq("ignore", 1);
    endtask

    initial begin
        undef_req = 1'b0;
        set_ctx('0, '0, '0, '0, '0, '0, '0, '0, '0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 reset busy", busy, 0);
        check("R7 reset strobe", vec_valid, 0);
        t_reset_idle();
        t_basic();
        t_flags_clear();
        t_wrap();
        t_ignore_busy();
        t_basic();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule